// File: doc/BRIEF.md
# Shadow Memory Region Attribute Decoder

This block decides, for every access in the upper legacy memory window (C0000h to FFFFFh), whether a read and whether a write should be served by on-board DRAM or passed to the expansion bus. It keeps three 8-bit shadow-control bytes, which are loaded through a simple write port. Each byte is split into 2-bit routing codes. The lower two bytes give fine control over 16 KB pieces. The third byte gives coarse control over two 64 KB segments.

For any 20-bit address, the routing outputs are combinational. The block also has a flag that tells whether the top 64 KB segment, where the boot firmware lives, is read from DRAM. When a write or a warm reset changes a region's code, the block pulses that region's change strobe for one cycle. A cache or TLB manager can use the strobe to invalidate only what moved. A warm reset input returns the top segment to fully external routing and leaves every other setting as it was.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After `rst_n` is released, all three control bytes read back as zero, every address routes external for both reads and writes, and no change strobe is active.
- R2: A region's 2-bit code routes reads and writes separately. Code bit 1 set means reads go internal. Code bit 0 set means writes go internal. So code 0 is both external, 1 is write-internal only, 2 is read-internal only and 3 is both internal.
- R3: Control byte 0 (`wr_sel_i`=0) covers the C segment and control byte 1 (`wr_sel_i`=1) covers the D segment. In each of these bytes, bits [2k+1:2k] give the code for the 16 KB piece at segment base + k×4000h, for k = 0..3.
- R4: In control byte 2 (`wr_sel_i`=2), bits [7:6] give the code for all of E0000h–EFFFFh and bits [5:4] give the code for all of F0000h–FFFFFh. Bits [3:0] are stored but change no routing and raise no strobe.
- R5: An address below C0000h always routes external for reads and writes, whatever the control bytes hold.
- R6: A write with `wr_en_i` high replaces the selected byte at the clock edge, and routing reflects the new value from that edge on. A write with `wr_sel_i`=3 changes nothing.
- R7: `remap_o` bit i is high for exactly the one cycle after an update edge, and only when region i's code differs between the old and new values. Bits 0–3 are the C pieces in ascending address order, bits 4–7 are the D pieces, bit 8 is the E segment and bit 9 is the F segment.
- R8: `bios_shadow_o` equals bit 1 of the F-segment code, which is control byte 2 bit 5. It is high exactly when reads of F0000h–FFFFFh go internal.
- R9: A cycle with `soft_rst_i` high clears bits [5:4] of control byte 2 and keeps all other bits of all three bytes. Strobe bit 9 pulses if that clearing changed the F code.
- R10: When `soft_rst_i` and `wr_en_i` are high in the same cycle, the warm reset is applied and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears all control bytes |
| soft_rst_i | input | 1 | Warm reset: F segment back to external routing |
| wr_en_i | input | 1 | Write strobe for a control byte |
| wr_sel_i | input | 2 | Control byte select (0, 1, 2; 3 is ignored) |
| wr_data_i | input | 8 | New control byte value |
| addr_i | input | ADDR_W (20) | Access address to classify |
| rd_int_o | output | 1 | Read at `addr_i` is served by internal DRAM |
| wr_int_o | output | 1 | Write at `addr_i` is served by internal DRAM |
| bios_shadow_o | output | 1 | Top 64 KB segment is read from internal DRAM |
| remap_o | output | 10 | One-cycle per-region change strobes |
| cfg_o | output | 24 | Current control bytes, byte 0 in bits [7:0] |

## Verification
The assertions assume that `wr_en_i`, `wr_sel_i`, `wr_data_i` and `soft_rst_i` are settled before each rising edge. They also assume that a strobe can only come from a cycle in which one of the two update inputs was high. The bench meets this by driving every input on the falling edge and releasing the update inputs after exactly one edge. The strobe assertions compare each region's code across consecutive cycles, so they depend on the control bytes changing only through the write port or warm reset. The bench never forces state in any other way and never reads the design's internals: the routing and strobe values it expects come from its own model of the three bytes.

// File: rtl/shadow_attr_pkg.sv
`timescale 1ns/1ps
package shadow_attr_pkg;
    localparam int CTL_W    = 8;                  // width of one control byte
    localparam int FIELD_W  = 2;                  // routing code width
    localparam int SUBS     = CTL_W / FIELD_W;    // 16 KB pieces per fine byte
    localparam int NUM_CTL  = 3;                  // control bytes held
    localparam int NUM_REG  = 2 * SUBS + 2;       // fine pieces plus E and F segments
    localparam int IDX_W    = $clog2(NUM_REG);
    localparam int SEG_BYTE = 2;                  // byte holding the 64 KB segment codes
    localparam int E_LSB    = 6;                  // E segment field position
    localparam int F_LSB    = 4;                  // F segment field position
    localparam int IDX_E    = 2 * SUBS;
    localparam int IDX_F    = 2 * SUBS + 1;

    typedef enum logic [FIELD_W-1:0] {
        ROUTE_BUS    = 2'd0,
        ROUTE_WR_RAM = 2'd1,
        ROUTE_RD_RAM = 2'd2,
        ROUTE_RAM    = 2'd3
    } route_code_e;

    typedef struct packed {
        logic rd_int;
        logic wr_int;
    } route_t;

    typedef logic [NUM_CTL-1:0][CTL_W-1:0]   ctl_bank_t;
    typedef logic [NUM_REG-1:0][FIELD_W-1:0] code_vec_t;

    function automatic route_t code_to_route(input logic [FIELD_W-1:0] code);
        route_t r;
        r.rd_int = (code == ROUTE_RD_RAM) || (code == ROUTE_RAM);
        r.wr_int = (code == ROUTE_WR_RAM) || (code == ROUTE_RAM);
        return r;
    endfunction
endpackage

// File: rtl/shadow_field_map.sv
`timescale 1ns/1ps
module shadow_field_map
    import shadow_attr_pkg::*;
(
    input  ctl_bank_t ctl_i,
    output code_vec_t code_o
);
    // Fine bytes: one code per 16 KB piece, ascending address order.
    for (genvar k = 0; k < SUBS; k++) begin : g_fine
        assign code_o[k]        = ctl_i[0][k*FIELD_W +: FIELD_W];
        assign code_o[SUBS + k] = ctl_i[1][k*FIELD_W +: FIELD_W];
    end
    // Coarse byte: only the upper two fields route anything.
    assign code_o[IDX_E] = ctl_i[SEG_BYTE][E_LSB +: FIELD_W];
    assign code_o[IDX_F] = ctl_i[SEG_BYTE][F_LSB +: FIELD_W];
endmodule

// File: rtl/shadow_addr_decode.sv
`timescale 1ns/1ps
module shadow_addr_decode
    import shadow_attr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_area_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int TOP_MSB   = ADDR_W - 1;
    localparam int SEG_MSB   = ADDR_W - 3;
    localparam int PIECE_MSB = ADDR_W - 5;

    logic [1:0] seg;
    logic [1:0] piece;

    always_comb begin
        in_area_o = &addr_i[TOP_MSB -: 2];
        seg       = addr_i[SEG_MSB -: 2];
        piece     = addr_i[PIECE_MSB -: 2];
        unique case (seg)
            2'd0:    idx_o = IDX_W'(piece);
            2'd1:    idx_o = IDX_W'(SUBS) + IDX_W'(piece);
            2'd2:    idx_o = IDX_W'(IDX_E);
            default: idx_o = IDX_W'(IDX_F);
        endcase
    end
endmodule

// File: rtl/shadow_change_detect.sv
`timescale 1ns/1ps
module shadow_change_detect
    import shadow_attr_pkg::*;
(
    input  code_vec_t          old_i,
    input  code_vec_t          new_i,
    output logic [NUM_REG-1:0] diff_o
);
    for (genvar r = 0; r < NUM_REG; r++) begin : g_cmp
        assign diff_o[r] = |(old_i[r] ^ new_i[r]);
    end
endmodule

// File: rtl/shadow_attr_decoder.sv
`timescale 1ns/1ps
module shadow_attr_decoder
    import shadow_attr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst_i,
    input  logic                     wr_en_i,
    input  logic [1:0]               wr_sel_i,
    input  logic [CTL_W-1:0]         wr_data_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic                     rd_int_o,
    output logic                     wr_int_o,
    output logic                     bios_shadow_o,
    output logic [NUM_REG-1:0]       remap_o,
    output logic [NUM_CTL*CTL_W-1:0] cfg_o
);
    typedef struct packed {
        ctl_bank_t          ctl;
        logic [NUM_REG-1:0] remap;
    } state_t;

    state_t             st_d, st_q;
    ctl_bank_t          ctl_nxt;
    code_vec_t          code_q, code_nxt;
    logic [NUM_REG-1:0] code_diff;
    logic               in_area;
    logic [IDX_W-1:0]   reg_idx;
    route_t             route;

    // Candidate next control bytes; warm reset outranks a write.
    always_comb begin
        ctl_nxt = st_q.ctl;
        if (soft_rst_i) begin
            ctl_nxt[SEG_BYTE][F_LSB +: FIELD_W] = '0;
        end else if (wr_en_i && (32'(wr_sel_i) < NUM_CTL)) begin
            ctl_nxt[wr_sel_i] = wr_data_i;
        end
    end

    shadow_field_map u_map_q   (.ctl_i(st_q.ctl), .code_o(code_q));
    shadow_field_map u_map_nxt (.ctl_i(ctl_nxt),  .code_o(code_nxt));

    shadow_change_detect u_diff (
        .old_i (code_q),
        .new_i (code_nxt),
        .diff_o(code_diff)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ctl   = ctl_nxt;
        st_d.remap = code_diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    shadow_addr_decode #(.ADDR_W(ADDR_W)) u_addr (
        .addr_i   (addr_i),
        .in_area_o(in_area),
        .idx_o    (reg_idx)
    );

    always_comb begin
        route    = code_to_route(code_q[reg_idx]);
        rd_int_o = in_area & route.rd_int;
        wr_int_o = in_area & route.wr_int;
    end

    assign bios_shadow_o = code_to_route(code_q[IDX_F]).rd_int;
    assign remap_o       = st_q.remap;
    assign cfg_o         = st_q.ctl;

    // ---------------- assertions ----------------
    assert_outside_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i[ADDR_W-1 -: 2] != 2'b11) |-> (!rd_int_o && !wr_int_o));

    assert_bios_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bios_shadow_o && (&addr_i[ADDR_W-1 -: 4])) |-> rd_int_o);

    assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|remap_o) |-> $past(wr_en_i || soft_rst_i));

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst_i) |-> !bios_shadow_o);

    assert_soft_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst_i) |-> (cfg_o[CTL_W*2-1:0] == $past(cfg_o[CTL_W*2-1:0])));

    assert_soft_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(soft_rst_i) && $past(wr_en_i)) |-> (cfg_o[CTL_W*2-1:0] == $past(cfg_o[CTL_W*2-1:0])));

    for (genvar r = 0; r < NUM_REG; r++) begin : g_strobe_chk
        assert_remap_diff_R7: assert property (@(posedge clk) disable iff (!rst_n)
            remap_o[r] |-> (code_q[r] != $past(code_q[r])));
        assert_remap_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (code_q[r] != $past(code_q[r])) |-> remap_o[r]);
    end
endmodule

// File: tb/shadow_attr_decoder_tb.sv
`timescale 1ns/1ps
module shadow_attr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        soft_rst_i;
    logic        wr_en_i;
    logic [1:0]  wr_sel_i;
    logic [7:0]  wr_data_i;
    logic [19:0] addr_i;
    logic        rd_int_o, wr_int_o, bios_shadow_o;
    logic [9:0]  remap_o;
    logic [23:0] cfg_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [23:0] mv = '0;   // bench model of the three control bytes

    always #2 clk = ~clk;   // 250 MHz

    shadow_attr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .addr_i(addr_i),
        .rd_int_o(rd_int_o), .wr_int_o(wr_int_o), .bios_shadow_o(bios_shadow_o),
        .remap_o(remap_o), .cfg_o(cfg_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] fcode(input logic [23:0] m, input int r);
        if (r < 4)       return m[2*r +: 2];
        else if (r < 8)  return m[8 + 2*(r-4) +: 2];
        else if (r == 8) return m[22 +: 2];
        else             return m[20 +: 2];
    endfunction

    function automatic logic [9:0] strobes(input logic [23:0] o, input logic [23:0] n);
        logic [9:0] s;
        for (int r = 0; r < 10; r++) s[r] = (fcode(o, r) != fcode(n, r));
        return s;
    endfunction

    function automatic logic [1:0] exp_route(input logic [23:0] m, input logic [19:0] a);
        int r;
        logic [1:0] c;
        if (a[19:18] != 2'b11) return 2'b00;
        case (a[17:16])
            2'd0: r = int'(a[15:14]);
            2'd1: r = 4 + int'(a[15:14]);
            2'd2: r = 8;
            default: r = 9;
        endcase
        c = fcode(m, r);
        return {c[1], c[0]};   // {read internal, write internal}
    endfunction

    task automatic check_route(input string req, input logic [19:0] a);
        addr_i = a;
        #1;
        chk(req, $sformatf("route@%05h", a), {30'd0, rd_int_o, wr_int_o}, {30'd0, exp_route(mv, a)});
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 'h100000; a += 'h2000) begin
            check_route(req, 20'(a));
            check_route(req, 20'(a + 'h1FFF));
        end
    endtask

    task automatic do_write(input string req, input logic [1:0] sel, input logic [7:0] data);
        logic [23:0] nv;
        logic [9:0]  es;
        nv = mv;
        if (sel < 2'd3) nv[8*sel +: 8] = data;
        es = strobes(mv, nv);
        wr_sel_i = sel; wr_data_i = data; wr_en_i = 1'b1;
        tick();
        wr_en_i = 1'b0;
        mv = nv;
        chk(req, "cfg after write", {8'd0, cfg_o}, {8'd0, nv});
        chk("R7", "strobe after write", {22'd0, remap_o}, {22'd0, es});
        tick();
        chk("R7", "strobe one cycle only", {22'd0, remap_o}, 32'd0);
    endtask

    task automatic do_soft(input logic with_wr, input logic [1:0] sel, input logic [7:0] data);
        logic [23:0] nv;
        nv = mv;
        nv[21:20] = 2'b00;
        soft_rst_i = 1'b1; wr_en_i = with_wr; wr_sel_i = sel; wr_data_i = data;
        tick();
        soft_rst_i = 1'b0; wr_en_i = 1'b0;
        chk(with_wr ? "R10" : "R9", "cfg after warm reset", {8'd0, cfg_o}, {8'd0, nv});
        chk("R9", "strobe after warm reset", {22'd0, remap_o}, {22'd0, strobes(mv, nv)});
        chk("R9", "bios flag after warm reset", {31'd0, bios_shadow_o}, 32'd0);
        mv = nv;
        tick();
        chk("R7", "warm reset strobe one cycle", {22'd0, remap_o}, 32'd0);
    endtask

    task automatic t_reset_state();
        chk("R1", "cfg at reset", {8'd0, cfg_o}, 32'd0);
        chk("R1", "strobes at reset", {22'd0, remap_o}, 32'd0);
        chk("R1", "bios flag at reset", {31'd0, bios_shadow_o}, 32'd0);
        sweep("R1");
    endtask

    task automatic t_c_pieces();
        do_write("R3", 2'd0, 8'b11_10_01_00);
        check_route("R2", 20'hC0000);  // code 0
        check_route("R2", 20'hC3FFF);
        check_route("R2", 20'hC4000);  // code 1
        check_route("R2", 20'hC8000);  // code 2
        check_route("R2", 20'hCFFFF);  // code 3
        chk("R2", "code3 read", {31'd0, rd_int_o}, 32'd1);
        sweep("R3");
        do_write("R3", 2'd0, 8'b00_01_10_11);
        sweep("R3");
    endtask

    task automatic t_d_pieces();
        do_write("R3", 2'd1, 8'b01_11_00_10);
        check_route("R3", 20'hD0000);
        check_route("R3", 20'hD4000);
        check_route("R3", 20'hDC123);
        sweep("R3");
    endtask

    task automatic t_ef_segments();
        do_write("R4", 2'd2, 8'h9F);   // E code 2, F code 1, low nibble set
        check_route("R4", 20'hE0000);
        check_route("R4", 20'hEFFFF);
        check_route("R4", 20'hF8000);
        sweep("R4");
        do_write("R4", 2'd2, 8'h90);   // only bits [3:0] differ: no strobe, same routing
        sweep("R4");
    endtask

    task automatic t_ignored_writes();
        do_write("R7", 2'd0, mv[7:0]);  // same value, no strobe
        do_write("R6", 2'd3, 8'hFF);    // invalid select, nothing changes
        sweep("R6");
    endtask

    task automatic t_below_area();
        do_write("R6", 2'd0, 8'hFF);
        do_write("R6", 2'd1, 8'hFF);
        do_write("R6", 2'd2, 8'hFF);
        check_route("R5", 20'h00000);
        check_route("R5", 20'hBFFFF);
        check_route("R5", 20'h7C000);
        check_route("R5", 20'h3F000);
        sweep("R5");
    endtask

    task automatic t_bios_flag();
        do_write("R8", 2'd2, 8'h20);
        chk("R8", "bios flag code 2", {31'd0, bios_shadow_o}, 32'd1);
        check_route("R8", 20'hF0000);
        do_write("R8", 2'd2, 8'h10);
        chk("R8", "bios flag code 1", {31'd0, bios_shadow_o}, 32'd0);
        do_write("R8", 2'd2, 8'h30);
        chk("R8", "bios flag code 3", {31'd0, bios_shadow_o}, 32'd1);
    endtask

    task automatic t_soft_reset();
        do_write("R9", 2'd2, 8'hFF);
        do_soft(1'b0, 2'd0, 8'h00);
        check_route("R9", 20'hE4000);
        check_route("R9", 20'hF0000);
        sweep("R9");
        do_soft(1'b0, 2'd0, 8'h00);    // already clear: no strobe
    endtask

    task automatic t_soft_vs_write();
        do_write("R10", 2'd2, 8'h30);
        do_soft(1'b1, 2'd0, 8'h5A);    // write to byte 0 must be dropped
        sweep("R10");
    endtask

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; soft_rst_i = 1'b0; wr_en_i = 1'b0;
        wr_sel_i = 2'd0; wr_data_i = 8'd0; addr_i = 20'd0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset_state();
        t_c_pieces();
        t_d_pieces();
        t_ef_segments();
        t_ignored_writes();
        t_below_area();
        t_bios_flag();
        t_soft_reset();
        t_soft_vs_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule